// File: doc/BRIEF.md
# Bridge I/O and Memory Forwarding Decoder

This block sits in a two-sided bus bridge and decides, for every I/O or memory access that reaches the bridge, whether the bridge claims it and forwards it to the other side. Accesses seen on the primary side can be sent downstream. Accesses seen on the secondary side can be sent upstream. The decision uses three address windows: one I/O window and two memory windows, one of which is the prefetchable window. It also uses three command enables and a legacy-ISA aliasing mode.

Software writes the window and control registers through a simple write port. The bus front end presents each access as a one-cycle request strobe carrying the address, the access kind and the arrival side. One clock later the block returns a registered verdict: claimed or ignored, and, when claimed, whether the access travels upstream.

In ISA mode, the part of I/O space below 64KB is split inside every aligned 1KB block. The low 256 bytes of each block belong to the secondary side and travel downstream. The upper 768 bytes belong to the primary side and travel upstream, even where they fall inside the I/O window.

Top module: `brg_fwd_decode`

## Requirements
- R1: After reset, all window registers and enables read as zero and all response outputs are low. A write with `cfg_we` high stores `cfg_wdata` into the register chosen by `cfg_sel`. The select codes are: 0 I/O base, 1 I/O limit, 2 memory base, 3 memory limit, 4 prefetchable base, 5 prefetchable limit, 6 control. In the control word, bit0 is the I/O enable, bit1 the memory enable, bit2 the master enable and bit3 the ISA mode.
- R2: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. `rsp_claim` and `rsp_up` are low whenever `rsp_valid` is low.
- R3: The I/O window has 4KB granularity: only address bits [31:12] of its base and limit are kept, and the window covers base[31:12]:000h up to limit[31:12]:FFFh. The memory windows work the same way with 1MB granularity, using bits [31:20]. A window whose base is above its limit matches nothing.
- R4: A primary I/O access is claimed for downstream only when the I/O enable is set and the address lies in the I/O window. It is otherwise ignored, subject to R5.
- R5: With ISA mode set, a primary I/O access whose address bits [31:16] are zero is claimed only if its address bits [9:8] are 00. Offsets 100h to 3FFh of each 1KB block are not claimed.
- R6: For I/O addresses at or above 10000h, ISA mode has no effect. Both directions follow only the I/O window.
- R7: A secondary I/O access is claimed for upstream when the master enable is set and either of two conditions holds. Either the address lies outside the I/O window, or ISA mode is set, address bits [31:16] are zero and address bits [9:8] are not 00.
- R8: A primary memory access is claimed for downstream when the memory enable is set and the address lies in the memory window or in the prefetchable window.
- R9: A secondary memory access is claimed for upstream when the master enable is set and the address lies outside both memory windows.
- R10: `rsp_up` is 1 for a claimed access that arrived on the secondary side and 0 for every other access.
- R11: A register write takes effect for requests in the following cycles. A request presented in the same cycle as a write is decided with the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select code (see R1) |
| cfg_wdata | input | ADDR_W | Register write data |
| req_valid | input | 1 | Access request strobe |
| req_addr | input | ADDR_W | Access address |
| req_is_mem | input | 1 | 1 = memory access, 0 = I/O access |
| req_from_sec | input | 1 | 1 = arrived on secondary side, 0 = primary side |
| rsp_valid | output | 1 | Verdict valid, one cycle after the request |
| rsp_claim | output | 1 | Access is claimed and forwarded |
| rsp_up | output | 1 | Claimed access travels upstream |

## Verification
Every verdict is due exactly one clock after its request strobe. The bench drives a request on a falling edge and reads the verdict on the next falling edge, after the single output register has loaded. A register write is driven on a falling edge and counts as committed from the next rising edge. Requests issued in the same cycle as a write are checked against the old register image, and requests issued later against the new one. Idle cycles are checked for a low `rsp_valid` one clock after the strobe drops.

// File: rtl/brg_fwd_pkg.sv
package brg_fwd_pkg;

  typedef enum logic [2:0] {
    SEL_IO_BASE  = 3'd0,
    SEL_IO_LIM   = 3'd1,
    SEL_MEM_BASE = 3'd2,
    SEL_MEM_LIM  = 3'd3,
    SEL_PF_BASE  = 3'd4,
    SEL_PF_LIM   = 3'd5,
    SEL_CTRL     = 3'd6
  } cfg_sel_e;

  // Control word: bit3 isa, bit2 master, bit1 mem_en, bit0 io_en
  typedef struct packed {
    logic isa;
    logic master;
    logic mem_en;
    logic io_en;
  } ctl_t;

  localparam int CTL_W = 4;

endpackage

// File: rtl/brg_cfg_regs.sv
module brg_cfg_regs
  import brg_fwd_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int IO_GRAN  = 12,
  parameter int MEM_GRAN = 20,
  parameter int N_MEMWIN = 2,
  localparam int IO_HW   = ADDR_W - IO_GRAN,
  localparam int MEM_HW  = ADDR_W - MEM_GRAN
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             cfg_we,
  input  logic [2:0]                       cfg_sel,
  input  logic [ADDR_W-1:0]                cfg_wdata,
  output logic [IO_HW-1:0]                 io_base,
  output logic [IO_HW-1:0]                 io_lim,
  output logic [N_MEMWIN-1:0][MEM_HW-1:0]  mem_base,
  output logic [N_MEMWIN-1:0][MEM_HW-1:0]  mem_lim,
  output ctl_t                             ctl
);

  logic unused_wbits;
  assign unused_wbits = ^cfg_wdata[IO_GRAN-1:CTL_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      io_base <= '0;
      io_lim  <= '0;
      ctl     <= '0;
    end else if (cfg_we) begin
      if (cfg_sel == SEL_IO_BASE) io_base <= cfg_wdata[ADDR_W-1:IO_GRAN];
      if (cfg_sel == SEL_IO_LIM)  io_lim  <= cfg_wdata[ADDR_W-1:IO_GRAN];
      if (cfg_sel == SEL_CTRL)    ctl     <= ctl_t'(cfg_wdata[CTL_W-1:0]);
    end
  end

  for (genvar g = 0; g < N_MEMWIN; g++) begin : g_memwin
    localparam logic [2:0] BASE_SEL = 3'(SEL_MEM_BASE + 2 * g);
    localparam logic [2:0] LIM_SEL  = 3'(SEL_MEM_LIM + 2 * g);
    always_ff @(posedge clk) begin
      if (rst) begin
        mem_base[g] <= '0;
        mem_lim[g]  <= '0;
      end else if (cfg_we) begin
        if (cfg_sel == BASE_SEL) mem_base[g] <= cfg_wdata[ADDR_W-1:MEM_GRAN];
        if (cfg_sel == LIM_SEL)  mem_lim[g]  <= cfg_wdata[ADDR_W-1:MEM_GRAN];
      end
    end
  end

endmodule

// File: rtl/brg_win_match.sv
module brg_win_match #(
  parameter int ADDR_W = 32,
  parameter int GRAN   = 12,
  localparam int HW    = ADDR_W - GRAN
) (
  input  logic [HW-1:0] base,
  input  logic [HW-1:0] lim,
  input  logic [HW-1:0] page,
  output logic          hit
);

  logic win_ok;

  always_comb begin
    win_ok = (base <= lim);
    hit    = win_ok && (page >= base) && (page <= lim);
  end

endmodule

// File: rtl/brg_fwd_rule.sv
module brg_fwd_rule
  import brg_fwd_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ISA_SPAN_W = 16,
  parameter int ISA_BLK_W  = 10,
  parameter int ISA_FWD_W  = 8,
  localparam int HI_W      = ADDR_W - ISA_SPAN_W,
  localparam int OFS_W     = ISA_BLK_W - ISA_FWD_W
) (
  input  logic             is_mem,
  input  logic             from_sec,
  input  logic [HI_W-1:0]  addr_hi,
  input  logic [OFS_W-1:0] addr_ofs,
  input  logic             io_hit,
  input  logic             mem_hit,
  input  ctl_t             ctl,
  output logic             claim,
  output logic             up
);

  logic below_span;
  logic isa_alias;

  always_comb begin
    below_span = (addr_hi == '0);
    isa_alias  = ctl.isa && below_span && (addr_ofs != '0);
    unique case ({is_mem, from_sec})
      2'b00:   claim = ctl.io_en  && io_hit && !isa_alias;
      2'b01:   claim = ctl.master && (!io_hit || isa_alias);
      2'b10:   claim = ctl.mem_en && mem_hit;
      default: claim = ctl.master && !mem_hit;
    endcase
    up = claim && from_sec;
  end

endmodule

// File: rtl/brg_fwd_decode.sv
module brg_fwd_decode
  import brg_fwd_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int IO_GRAN    = 12,
  parameter int MEM_GRAN   = 20,
  parameter int ISA_SPAN_W = 16,
  parameter int ISA_BLK_W  = 10,
  parameter int ISA_FWD_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_is_mem,
  input  logic              req_from_sec,
  output logic              rsp_valid,
  output logic              rsp_claim,
  output logic              rsp_up
);

  localparam int N_MEMWIN = 2;
  localparam int IO_HW    = ADDR_W - IO_GRAN;
  localparam int MEM_HW   = ADDR_W - MEM_GRAN;

  logic [IO_HW-1:0]                io_base_q, io_lim_q;
  logic [N_MEMWIN-1:0][MEM_HW-1:0] mem_base_q, mem_lim_q;
  ctl_t                            ctl_q;
  logic                            io_hit;
  logic [N_MEMWIN-1:0]             win_hit;
  logic                            claim_d, up_d;

  logic unused_abits;
  assign unused_abits = ^{req_addr[IO_GRAN-1:ISA_BLK_W], req_addr[ISA_FWD_W-1:0]};

  brg_cfg_regs #(
    .ADDR_W(ADDR_W), .IO_GRAN(IO_GRAN), .MEM_GRAN(MEM_GRAN), .N_MEMWIN(N_MEMWIN)
  ) i_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .io_base(io_base_q), .io_lim(io_lim_q),
    .mem_base(mem_base_q), .mem_lim(mem_lim_q), .ctl(ctl_q)
  );

  brg_win_match #(.ADDR_W(ADDR_W), .GRAN(IO_GRAN)) i_io_win (
    .base(io_base_q), .lim(io_lim_q),
    .page(req_addr[ADDR_W-1:IO_GRAN]), .hit(io_hit)
  );

  for (genvar g = 0; g < N_MEMWIN; g++) begin : g_mwin
    brg_win_match #(.ADDR_W(ADDR_W), .GRAN(MEM_GRAN)) i_mem_win (
      .base(mem_base_q[g]), .lim(mem_lim_q[g]),
      .page(req_addr[ADDR_W-1:MEM_GRAN]), .hit(win_hit[g])
    );
  end

  brg_fwd_rule #(
    .ADDR_W(ADDR_W), .ISA_SPAN_W(ISA_SPAN_W),
    .ISA_BLK_W(ISA_BLK_W), .ISA_FWD_W(ISA_FWD_W)
  ) i_rule (
    .is_mem(req_is_mem), .from_sec(req_from_sec),
    .addr_hi(req_addr[ADDR_W-1:ISA_SPAN_W]),
    .addr_ofs(req_addr[ISA_BLK_W-1:ISA_FWD_W]),
    .io_hit(io_hit), .mem_hit(|win_hit), .ctl(ctl_q),
    .claim(claim_d), .up(up_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_claim <= 1'b0;
      rsp_up    <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_claim <= req_valid && claim_d;
      rsp_up    <= req_valid && up_d;
    end
  end

endmodule

// File: rtl/brg_fwd_checker.sv
module brg_fwd_checker (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_is_mem,
  input logic req_from_sec,
  input logic rsp_valid,
  input logic rsp_claim,
  input logic rsp_up,
  input logic io_en,
  input logic mem_en,
  input logic master
);

  assert_rsp_due_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  assert_rsp_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && !rsp_claim && !rsp_up));

  assert_up_needs_claim_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_up |-> rsp_claim);

  assert_dir_matches_side_R10: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (!rsp_claim || (rsp_up == $past(req_from_sec))));

  assert_upstream_gated_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_from_sec && !master) |=> !rsp_claim);

  assert_io_down_gated_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_from_sec && !req_is_mem && !io_en) |=> !rsp_claim);

  assert_mem_down_gated_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_from_sec && req_is_mem && !mem_en) |=> !rsp_claim);

endmodule

bind brg_fwd_decode brg_fwd_checker i_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_is_mem(req_is_mem),
  .req_from_sec(req_from_sec), .rsp_valid(rsp_valid), .rsp_claim(rsp_claim),
  .rsp_up(rsp_up), .io_en(ctl_q.io_en), .mem_en(ctl_q.mem_en), .master(ctl_q.master)
);

// File: tb/test_brg_fwd_decode.sv
module test_brg_fwd_decode;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_is_mem = 1'b0;
  logic        req_from_sec = 1'b0;
  logic        rsp_valid, rsp_claim, rsp_up;

  int checks = 0;
  int errors = 0;

  // bench register image
  logic [31:0] m_reg [0:6];

  always #(CLK_PERIOD/2) clk = ~clk;

  brg_fwd_decode i_brg_fwd_decode (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_addr(req_addr), .req_is_mem(req_is_mem),
    .req_from_sec(req_from_sec), .rsp_valid(rsp_valid), .rsp_claim(rsp_claim),
    .rsp_up(rsp_up)
  );

  task automatic check(string tag, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual valid/claim/up=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic bit in_win(logic [31:0] b, logic [31:0] l, logic [31:0] a, int g);
    logic [31:0] bb, ll, aa;
    bb = b >> g; ll = l >> g; aa = a >> g;
    return (bb <= ll) && (aa >= bb) && (aa <= ll);
  endfunction

  // expected {claim, up} from the requirements
  function automatic logic [1:0] expect_rsp(logic [31:0] a, bit mem, bit sec);
    bit iow, mw, alias_top, c;
    logic [3:0] cw;
    cw = m_reg[6][3:0];
    iow = in_win(m_reg[0], m_reg[1], a, 12);
    mw = in_win(m_reg[2], m_reg[3], a, 20) || in_win(m_reg[4], m_reg[5], a, 20);
    alias_top = cw[3] && (a[31:16] == 16'h0) && (a[9:8] != 2'b00);
    if (!mem && !sec)     c = cw[0] && iow && !alias_top;
    else if (!mem && sec) c = cw[2] && (!iow || alias_top);
    else if (mem && !sec) c = cw[1] && mw;
    else                  c = cw[2] && !mw;
    return {c, c && sec};
  endfunction

  task automatic wr(logic [2:0] sel, logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
    m_reg[sel] = data;
  endtask

  task automatic req(string tag, logic [31:0] a, bit mem, bit sec);
    logic [1:0] e;
    e = expect_rsp(a, mem, sec);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_is_mem = mem; req_from_sec = sec;
    @(negedge clk);
    req_valid = 1'b0;
    check(tag, {rsp_valid, rsp_claim, rsp_up}, {1'b1, e});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [1:0] e;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 7; i++) m_reg[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset state", {rsp_valid, rsp_claim, rsp_up}, 3'b000);
    req("R1 enables clear after reset", 32'h0000_0010, 1'b0, 1'b0);
    @(negedge clk);
    check("R2 idle cycle", {rsp_valid, rsp_claim, rsp_up}, 3'b000);

    // I/O window 0x2000..0x5FFF, all enables, ISA off
    wr(3'd0, 32'h0000_2ABC);
    wr(3'd1, 32'h0000_5123);
    wr(3'd6, 32'h0000_0007);
    req("R4 primary io in window", 32'h0000_2000, 1'b0, 1'b0);
    req("R3 io limit top byte", 32'h0000_5FFF, 1'b0, 1'b0);
    req("R3 io just above limit", 32'h0000_6000, 1'b0, 1'b0);
    req("R3 io just below base", 32'h0000_1FFF, 1'b0, 1'b0);
    req("R7 secondary io inside window", 32'h0000_3000, 1'b0, 1'b1);
    req("R7 R10 secondary io outside window", 32'h0000_7000, 1'b0, 1'b1);

    // ISA mode on
    wr(3'd6, 32'h0000_000F);
    req("R5 isa low quarter", 32'h0000_20FF, 1'b0, 1'b0);
    req("R5 isa offset 100h", 32'h0000_2100, 1'b0, 1'b0);
    req("R5 isa offset 3FFh", 32'h0000_23FF, 1'b0, 1'b0);
    req("R5 isa next block", 32'h0000_2400, 1'b0, 1'b0);
    req("R7 isa secondary upper alias", 32'h0000_2100, 1'b0, 1'b1);
    req("R7 isa secondary low quarter", 32'h0000_2000, 1'b0, 1'b1);

    // window above 64KB
    wr(3'd0, 32'h0001_0000);
    wr(3'd1, 32'h0001_F000);
    req("R6 primary io above span isa on", 32'h0001_0100, 1'b0, 1'b0);
    req("R6 secondary io above span in window", 32'h0001_0300, 1'b0, 1'b1);

    // memory windows
    wr(3'd2, 32'h8000_0000);
    wr(3'd3, 32'h80F0_1234);
    wr(3'd4, 32'hC000_0000);
    wr(3'd5, 32'hC000_0000);
    req("R8 primary mem top of window", 32'h80FF_FFFF, 1'b1, 1'b0);
    req("R8 primary mem prefetch window", 32'hC00F_FFFF, 1'b1, 1'b0);
    req("R3 mem above prefetch limit", 32'hC010_0000, 1'b1, 1'b0);
    req("R9 secondary mem outside", 32'h9000_0000, 1'b1, 1'b1);
    req("R9 secondary mem inside", 32'h8000_0000, 1'b1, 1'b1);
    wr(3'd4, 32'hD000_0000);
    req("R3 disabled prefetch window", 32'hC000_0000, 1'b1, 1'b0);
    req("R3 disabled window lets secondary up", 32'hC800_0000, 1'b1, 1'b1);

    // enables off
    wr(3'd6, 32'h0000_0000);
    req("R9 master off mem", 32'h9000_0000, 1'b1, 1'b1);
    req("R7 master off io", 32'h0000_7000, 1'b0, 1'b1);
    req("R8 mem enable off", 32'h8000_0000, 1'b1, 1'b0);
    req("R4 io enable off", 32'h0001_0000, 1'b0, 1'b0);

    // R11: write and request in the same cycle
    e = expect_rsp(32'h9000_0000, 1'b1, 1'b1);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'd6; cfg_wdata = 32'h0000_0004;
    req_valid = 1'b1; req_addr = 32'h9000_0000; req_is_mem = 1'b1; req_from_sec = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    m_reg[6] = 32'h0000_0004;
    check("R11 same-cycle write uses old", {rsp_valid, rsp_claim, rsp_up}, {1'b1, e});
    req("R11 next request uses new", 32'h9000_0000, 1'b1, 1'b1);

    // constrained random
    for (int n = 0; n < 600; n++) begin
      if (n % 25 == 0) begin
        wr(3'd0, ($urandom % 24) << 12);
        wr(3'd1, ($urandom % 24) << 12);
        wr(3'd2, $urandom & 32'hF0F0_0000);
        wr(3'd3, $urandom & 32'hF0F0_0000);
        wr(3'd4, $urandom & 32'hF0F0_0000);
        wr(3'd5, $urandom & 32'hF0F0_0000);
        wr(3'd6, $urandom & 32'hF);
      end
      begin
        bit mem, sec;
        logic [31:0] a;
        mem = $urandom % 2;
        sec = $urandom % 2;
        a = mem ? ($urandom & 32'hF0FF_FFFF) : ($urandom % 32'h0001_8000);
        req(mem ? (sec ? "R9 random" : "R8 random") : (sec ? "R7 random" : "R5 random"),
            a, mem, sec);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule